// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block carries out single Clause 22 management transactions toward an external PHY. The host writes a 32-bit command word that names the operation, the PHY address, the register address and, for writes, the data. The controller then serialises one complete frame on the two-wire management bus. It generates MDC from the system clock and drives or releases MDIO as the frame requires.

For a read, the controller samples the sixteen data bits that the PHY returns and places them in the low half of the stored command word. It leaves every other field of the word unchanged. The bus is assumed to be pulled high, so a read addressed to an absent PHY returns all ones.

A busy flag covers the whole transaction. Software polls it, and then reads the updated word.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, `busy`, `mdc` and `mdio_oe` are low and `cmd_word` is zero.
- R2: Command word fields: data at bits 15:0, register address at 22:18, PHY address at 27:23, operation at 29:28, start code at 31:30. A write strobe while idle with operation 3 (read) or 2 (write) stores the word and raises `busy` on the next cycle.
- R3: A write strobe while idle with operation 0 or 1 stores the word but starts no frame: `busy` and `mdc` stay low.
- R4: Each frame is 64 bits, sent MSB first in this order: 32 ones, then the start code from bits 31:30, then the wire operation (`10` for read, `01` for write), then the PHY address, then the register address.
- R5: In a write frame, the controller drives the turnaround as 1 then 0, then data bits 15:0 MSB first, with `mdio_oe` high for all 64 bits.
- R6: In a read frame, `mdio_oe` is low for the last 18 bit times (turnaround plus data). The data is sampled at each MDC rising edge and replaces only bits 15:0 of `cmd_word` when the frame ends.
- R7: A read during which nothing pulls MDIO low (no PHY answering) leaves 0xFFFF in bits 15:0.
- R8: `mdc_div_sel` values 0 to 7 give an MDC period of 8, 16, 32, 48, 64, 96, 128 and 224 clocks, with equal low and high halves. The select is taken when a command is accepted. `busy` stays high for exactly 64 MDC periods, and `mdc` is low whenever `busy` is low.
- R9: `mdio_out` and `mdio_oe` change only while MDC is low. They are stable for the whole high half of every bit.
- R10: A write strobe while `busy` is high is ignored: `cmd_word` and the frame in progress are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Host write strobe for the command word |
| cmd_wdata | input | 32 | Command word written by the host |
| mdc_div_sel | input | 3 | MDC divisor select |
| mdio_in | input | 1 | Sensed level of the MDIO line |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable |
| busy | output | 1 | Transaction in progress |
| cmd_word | output | 32 | Stored command word, read data merged in bits 15:0 |

## Verification
The assertions take for granted that reset is held until the internal synchroniser has released it before any write strobe arrives. They also take for granted that the host holds `cmd_wdata` steady only in the strobe cycle that matters, since that is the only cycle they examine.

The stimulus issues strobes only after the reset release has settled. Its PHY model drives `mdio_in` only on MDC falling edges, so the line never changes near a sampling point. Strobes issued during a frame are single-cycle pulses placed in the middle of the frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int CMD_W  = 32;
  localparam int DATA_W = 16;
  localparam int HALF_W = 7;

  typedef struct packed {
    logic [1:0]        st;
    logic [1:0]        op;
    logic [4:0]        phy;
    logic [4:0]        regad;
    logic [1:0]        rsvd;
    logic [DATA_W-1:0] data;
  } mgmt_cmd_t;

  localparam logic [1:0] OP_RD   = 2'd3;
  localparam logic [1:0] OP_WR   = 2'd2;
  localparam logic [1:0] WIRE_RD = 2'b10;
  localparam logic [1:0] WIRE_WR = 2'b01;

  // Half of the MDC period, in system clocks, for each select value.
  function automatic logic [HALF_W-1:0] mdc_half(input logic [2:0] sel);
    logic [HALF_W-1:0] h;
    case (sel)
      3'd0:    h = HALF_W'(4);
      3'd1:    h = HALF_W'(8);
      3'd2:    h = HALF_W'(16);
      3'd3:    h = HALF_W'(24);
      3'd4:    h = HALF_W'(32);
      3'd5:    h = HALF_W'(48);
      3'd6:    h = HALF_W'(64);
      default: h = HALF_W'(112);
    endcase
    return h;
  endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              mdc,
  output logic              half_end
);

  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic              phase_q, phase_d;
  logic              at_end;

  assign at_end   = (cnt_q == half - HALF_W'(1));
  assign half_end = run & at_end;
  assign mdc      = phase_q;

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (!run) begin
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (at_end) begin
      cnt_d   = '0;
      phase_d = ~phase_q;
    end else begin
      cnt_d   = cnt_q + HALF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
#(
  parameter int PREAMBLE_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mgmt_cmd_t         cmd,
  input  logic              mdc,
  input  logic              half_end,
  input  logic              mdio_in,
  output logic              busy,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data
);

  localparam int FRAME_BITS = PREAMBLE_BITS + 32;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] TA_BIT   = BIT_W'(FRAME_BITS - 18);
  localparam logic [BIT_W-1:0] DATA_BIT = BIT_W'(FRAME_BITS - DATA_W);

  logic                  busy_q, busy_d;
  logic                  rd_q, rd_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [FRAME_BITS-1:0] tx_q, tx_d;
  logic [DATA_W-1:0]     rx_q, rx_d;
  logic                  advance, sample, last;
  logic                  is_rd;
  logic [1:0]            wire_op, ta_bits;
  logic [DATA_W-1:0]     tx_data;

  // advance: end of the high half; sample: MDC about to rise
  assign advance = half_end & mdc;
  assign sample  = half_end & ~mdc;
  assign last    = (bit_q == LAST_BIT);

  assign is_rd   = (cmd.op == OP_RD);
  assign wire_op = is_rd ? WIRE_RD : WIRE_WR;
  assign ta_bits = is_rd ? 2'b11 : 2'b10;
  assign tx_data = is_rd ? {DATA_W{1'b1}} : cmd.data;

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      rd_d   = is_rd;
      bit_d  = '0;
      tx_d   = {{PREAMBLE_BITS{1'b1}}, cmd.st, wire_op, cmd.phy,
                cmd.regad, ta_bits, tx_data};
      rx_d   = '0;
    end else if (busy_q) begin
      if (sample && rd_q && (bit_q >= DATA_BIT)) begin
        rx_d = {rx_q[DATA_W-2:0], mdio_in};
      end
      if (advance) begin
        tx_d = {tx_q[FRAME_BITS-2:0], 1'b1};
        if (last) begin
          busy_d = 1'b0;
        end else begin
          bit_d = bit_q + BIT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign busy     = busy_q;
  assign mdio_oe  = busy_q & ~(rd_q & (bit_q >= TA_BIT));
  assign mdio_out = mdio_oe & tx_q[FRAME_BITS-1];
  assign rd_done  = busy_q & rd_q & advance & last;
  assign rd_data  = rx_q;

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int PREAMBLE_BITS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic [2:0]       mdc_div_sel,
  input  logic             mdio_in,
  output logic             mdc,
  output logic             mdio_out,
  output logic             mdio_oe,
  output logic             busy,
  output logic [CMD_W-1:0] cmd_word
);

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic              eng_busy, half_end, rd_done;
  logic [DATA_W-1:0] rd_data;
  logic              accept, op_ok, start;
  mgmt_cmd_t         new_cmd;
  logic [CMD_W-1:0]  cmd_q, cmd_d;
  logic              cmd_en;
  logic [HALF_W-1:0] half_q;

  assign new_cmd = mgmt_cmd_t'(cmd_wdata);
  assign op_ok   = (new_cmd.op == OP_RD) || (new_cmd.op == OP_WR);
  assign accept  = cmd_we & ~eng_busy;
  assign start   = accept & op_ok;

  always_comb begin
    cmd_d  = cmd_q;
    cmd_en = 1'b0;
    if (accept) begin
      cmd_d  = cmd_wdata;
      cmd_en = 1'b1;
    end else if (rd_done) begin
      cmd_d  = {cmd_q[CMD_W-1:DATA_W], rd_data};
      cmd_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmd_q  <= '0;
      half_q <= HALF_W'(4);
    end else begin
      if (cmd_en) cmd_q  <= cmd_d;
      if (start)  half_q <= mdc_half(mdc_div_sel);
    end
  end

  mdio_clk_div u_clk_div (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (eng_busy),
    .half     (half_q),
    .mdc      (mdc),
    .half_end (half_end)
  );

  mdio_frame_eng #(
    .PREAMBLE_BITS (PREAMBLE_BITS)
  ) u_frame_eng (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .cmd      (new_cmd),
    .mdc      (mdc),
    .half_end (half_end),
    .mdio_in  (mdio_in),
    .busy     (eng_busy),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .rd_done  (rd_done),
    .rd_data  (rd_data)
  );

  assign busy     = eng_busy;
  assign cmd_word = cmd_q;

endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        cmd_we,
  input logic [31:0] cmd_wdata,
  input logic        mdc,
  input logic        mdio_out,
  input logic        mdio_oe,
  input logic        busy,
  input logic [31:0] cmd_word
);

  // R2
  valid_op_start_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!busy && cmd_we && cmd_wdata[29]) |=> (busy && cmd_word == $past(cmd_wdata)));

  // R3
  bad_op_idle_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!busy && cmd_we && !cmd_wdata[29]) |=> (!busy && !mdc));

  // R8
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !busy |-> !mdc);

  // R9
  mdio_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

  // R10
  word_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (busy && $past(busy)) |-> $stable(cmd_word));

  // R6
  oe_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !busy |-> !mdio_oe);

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk chk_i (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .cmd_we    (cmd_we),
  .cmd_wdata (cmd_wdata),
  .mdc       (mdc),
  .mdio_out  (mdio_out),
  .mdio_oe   (mdio_oe),
  .busy      (busy),
  .cmd_word  (cmd_word)
);

// File: tb/mdio_mgmt_ctrl_tb_top.sv
module mdio_mgmt_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_we;
  logic [31:0] cmd_wdata;
  logic [2:0]  mdc_div_sel;
  logic        mdio_in;
  logic        mdc, mdio_out, mdio_oe, busy;
  logic [31:0] cmd_word;

  always #2 clk = ~clk;

  mdio_mgmt_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we      (cmd_we),
    .cmd_wdata   (cmd_wdata),
    .mdc_div_sel (mdc_div_sel),
    .mdio_in     (mdio_in),
    .mdc         (mdc),
    .mdio_out    (mdio_out),
    .mdio_oe     (mdio_oe),
    .busy        (busy),
    .cmd_word    (cmd_word)
  );

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [63:0] val;
    logic [63:0] oe;
    logic [31:0] word;
    int          cycles;
  } exp_t;

  exp_t sb_q[$];

  logic        phy_on;
  logic [15:0] phy_data;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: observes each frame, plays the PHY, compares on frame end.
  logic        mdc_prev  = 1'b0;
  logic        busy_prev = 1'b0;
  int          nrise, cyc, hicyc;
  logic [63:0] obs_val, obs_oe;

  always @(negedge clk) begin
    if (!rst_n) begin
      mdio_in = 1'b1;
      nrise = 0; cyc = 0; hicyc = 0;
    end else begin
      if (busy && !busy_prev) begin
        nrise = 0; cyc = 0; hicyc = 0;
        obs_val = '0; obs_oe = '0;
        mdio_in = 1'b1;
      end
      if (busy) cyc++;
      if (mdc) hicyc++;
      if (mdc && !mdc_prev) begin
        if (nrise < 64) begin
          obs_val[63-nrise] = mdio_out;
          obs_oe[63-nrise]  = mdio_oe;
        end
        nrise++;
      end
      if (mdc_prev && !mdc) begin
        if (phy_on && nrise == 47)                   mdio_in = 1'b0;
        else if (phy_on && nrise >= 48 && nrise <= 63) mdio_in = phy_data[63-nrise];
        else                                          mdio_in = 1'b1;
      end
      if (!busy && busy_prev) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R2", "unexpected frame", 64'(nrise), 64'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          // R4 R5 R6: bit pattern and drive enables
          check(obs_oe == e.oe, "R6", "drive-enable pattern", obs_oe, e.oe);
          check(((obs_val ^ e.val) & e.oe) == 64'd0, "R4", "frame bits",
                obs_val & e.oe, e.val & e.oe);
          check(nrise == 64, "R4", "bit count", 64'(nrise), 64'd64);
          // R8: frame length and equal halves
          check(cyc == e.cycles, "R8", "busy cycles", 64'(cyc), 64'(e.cycles));
          check(hicyc == e.cycles / 2, "R8", "mdc high cycles",
                64'(hicyc), 64'(e.cycles / 2));
          // R6 R7 R10: stored word after the frame
          check(cmd_word == e.word, "R6", "command word", 64'(cmd_word), 64'(e.word));
        end
      end
      mdc_prev  = mdc;
      busy_prev = busy;
    end
  end

  function automatic int divisor(input logic [2:0] s);
    case (s)
      3'd0: return 8;   3'd1: return 16;  3'd2: return 32;  3'd3: return 48;
      3'd4: return 64;  3'd5: return 96;  3'd6: return 128; default: return 224;
    endcase
  endfunction

  // Driver: pushes the expected frame, writes the command, waits for it.
  task automatic run_cmd(input logic [31:0] w, input logic [2:0] sel,
                         input bit present, input logic [15:0] pdata,
                         input bit poke, input logic [31:0] poke_word);
    exp_t e;
    bit   rd;
    rd = (w[29:28] == 2'd3);
    e.val    = {32'hFFFF_FFFF, w[31:30], rd ? 2'b10 : 2'b01, w[27:23], w[22:18],
                2'b10, w[15:0]};
    e.oe     = rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
    e.word   = rd ? {w[31:16], present ? pdata : 16'hFFFF} : w;
    e.cycles = 64 * divisor(sel);
    sb_q.push_back(e);
    phy_on   = present;
    phy_data = pdata;
    @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = w; mdc_div_sel = sel;
    @(negedge clk);
    cmd_we = 1'b0; mdc_div_sel = ~sel;
    // R2: busy already high one cycle after the strobe
    check(busy == 1'b1, "R2", "busy after accept", 64'(busy), 64'd1);
    if (poke) begin
      repeat (150) @(negedge clk);
      cmd_we = 1'b1; cmd_wdata = poke_word;
      @(negedge clk);
      cmd_we = 1'b0;
      // R10: strobe during a frame leaves the word alone
      check(cmd_word == w, "R10", "word after busy write", 64'(cmd_word), 64'(w));
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_we = 1'b0; cmd_wdata = '0; mdc_div_sel = '0;
    phy_on = 1'b0; phy_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check(busy == 1'b0 && mdc == 1'b0 && mdio_oe == 1'b0, "R1", "idle outputs",
          64'({busy, mdc, mdio_oe}), 64'd0);
    check(cmd_word == 32'd0, "R1", "reset word", 64'(cmd_word), 64'd0);

    // R5: write, fastest clock
    run_cmd({2'b01, 2'd2, 5'd3, 5'd17, 2'b00, 16'hBEEF}, 3'd0, 1'b1, 16'h0, 1'b0, 32'd0);
    // R6: read from a responding PHY
    run_cmd({2'b01, 2'd3, 5'd3, 5'd2, 2'b11, 16'h1234}, 3'd0, 1'b1, 16'hA5C3, 1'b0, 32'd0);
    // R7: read with nobody driving
    run_cmd({2'b01, 2'd3, 5'd9, 5'd31, 2'b10, 16'h0000}, 3'd1, 1'b0, 16'h0, 1'b0, 32'd0);
    // R8: remaining divisor settings
    run_cmd({2'b01, 2'd2, 5'd31, 5'd0, 2'b00, 16'h5A5A}, 3'd2, 1'b1, 16'h0, 1'b0, 32'd0);
    run_cmd({2'b01, 2'd3, 5'd1, 5'd5, 2'b00, 16'hFFFF}, 3'd3, 1'b1, 16'h0001, 1'b0, 32'd0);
    run_cmd({2'b01, 2'd2, 5'd16, 5'd8, 2'b01, 16'h8001}, 3'd4, 1'b1, 16'h0, 1'b0, 32'd0);
    run_cmd({2'b01, 2'd3, 5'd0, 5'd1, 2'b00, 16'h0F0F}, 3'd5, 1'b1, 16'h8000, 1'b0, 32'd0);
    run_cmd({2'b10, 2'd2, 5'd21, 5'd10, 2'b00, 16'h0001}, 3'd6, 1'b1, 16'h0, 1'b0, 32'd0);
    run_cmd({2'b01, 2'd3, 5'd7, 5'd30, 2'b00, 16'h0000}, 3'd7, 1'b1, 16'h6E19, 1'b0, 32'd0);
    // R10: writes during a busy frame
    run_cmd({2'b01, 2'd3, 5'd4, 5'd4, 2'b00, 16'h0000}, 3'd0, 1'b1, 16'hC0DE, 1'b1,
            {2'b01, 2'd2, 5'd1, 5'd1, 2'b00, 16'h1111});
    run_cmd({2'b01, 2'd2, 5'd2, 5'd6, 2'b00, 16'h7777}, 3'd0, 1'b1, 16'h0, 1'b1,
            {2'b01, 2'd1, 5'd1, 5'd1, 2'b00, 16'h2222});

    // R3: operation codes 0 and 1 start nothing
    for (int op = 0; op < 2; op++) begin
      logic [31:0] w;
      w = {2'b01, 2'(op), 5'd5, 5'd5, 2'b00, 16'h4242};
      @(negedge clk);
      cmd_we = 1'b1; cmd_wdata = w;
      @(negedge clk);
      cmd_we = 1'b0;
      repeat (40) begin
        if (busy || mdc || mdio_oe) break;
        @(negedge clk);
      end
      check(!busy && !mdc && !mdio_oe, "R3", "no frame for bad op",
            64'({busy, mdc, mdio_oe}), 64'd0);
      check(cmd_word == w, "R3", "word stored", 64'(cmd_word), 64'(w));
    end

    check(sb_q.size() == 0, "R4", "frames left in scoreboard", 64'(sb_q.size()), 64'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule